// File: doc/BRIEF.md
# Polled Output Port with Ready/Busy Handshake

This block is a single-word output peripheral. A host on a small register bus loads one data word, then hands it to the controller. The controller delivers that word to a downstream device over a valid/accept pair. Two status flags decide who owns the data register. The host sets `ready` only after it has written the data. The controller answers by raising `busy` and clearing `ready` on the same clock edge, and it drops `busy` once the device has taken the word. A host that follows this protocol polls `busy` until it is clear, writes the data register, then sets `ready`.

A small state machine controls the transfer. It has two states, `ST_IDLE` and `ST_SEND`. The transition `ST_IDLE -> ST_SEND` (take) fires when `ready` is seen set. The transition `ST_SEND -> ST_IDLE` (release) fires when the device asserts accept while valid is high. In every other case the state holds. When a release happens while the interrupt enable is set, an interrupt-pending flag is set and drives the `irq` output. The host clears that flag by writing 1 to it. If the host writes the data register while `busy` is set, the write is dropped and a sticky overrun flag records the mistake.

Top module: `polled_out_port`

## Requirements
- R1: After reset, the status register reads 0 (ready, busy, pending, overrun and enable are all clear), `dev_valid` is low and `irq` is low.
- R2: A write to address 0 while busy is clear updates the data register, and a read of address 0 returns the new value.
- R3: When ready is set and busy is clear, the next clock edge sets busy, clears ready, raises `dev_valid` and presents the data register on `dev_data`. If a host write tries to set ready on that same edge, the clear wins.
- R4: While `dev_valid` is high and `dev_accept` is low, `dev_valid` stays high and `dev_data` does not change.
- R5: An edge with `dev_valid` and `dev_accept` both high ends the transfer: after that edge, `dev_valid` and busy are low. Each setting of ready produces exactly one transfer. `dev_accept` while `dev_valid` is low has no effect.
- R6: A write to address 0 while busy is set leaves the data register unchanged and sets the overrun bit. Only reset clears the overrun bit.
- R7: When a transfer ends while the enable bit is 1, the pending bit and `irq` become 1 on that same edge. When the enable bit is 0, they do not.
- R8: Writing the status register with bit 2 = 1 clears the pending bit, and writing bit 2 = 0 leaves it as it was. If a new completion and a clear happen on the same edge, the set wins.
- R9: Address 0 reads the data register. Address 1 reads the status register: bit 0 ready, bit 1 busy, bit 2 pending, bit 3 overrun, bit 4 enable, all other bits 0. A status write sets ready when bit 0 = 1 and loads enable from bit 4. Addresses 2 and 3 read 0 and ignore writes. `bus_rdata` is 0 whenever `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address (0 data, 1 status) |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, 0 when not reading |
| dev_valid | output | 1 | Word on `dev_data` is offered to the device |
| dev_accept | input | 1 | Device takes the offered word |
| dev_data | output | DATA_W | Word offered to the device |
| irq | output | 1 | Completion interrupt, equals the pending bit |

## Verification
The bench targets the following corner cases:
- **Data write during a transfer.** A design that let this write through would change `dev_data` under a valid offer.
- **Enable bit at completion.** Completions are run with the enable bit both set and clear. A design that ignored the enable bit would raise `irq` when it should stay low.
- **Pending bit clearing.** Status writes with bit 2 both 0 and 1 expose a wrong write-1-to-clear decode.
- **Accept with no offer.** Random `dev_accept` pulses while idle would create phantom transfers or phantom interrupts in a design that does not qualify accept with valid.
- **Ready handling.** Re-setting ready during a transfer shows whether the controller starts exactly one new transfer per ready.
- **Unused addresses.** Writes and reads at addresses 2 and 3 show whether they alias onto real registers.

// File: rtl/pop_pkg.sv
`timescale 1ns/1ps
package pop_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } pop_state_e;

    localparam int unsigned BIT_RDY = 0;
    localparam int unsigned BIT_BSY = 1;
    localparam int unsigned BIT_PND = 2;
    localparam int unsigned BIT_OVR = 3;
    localparam int unsigned BIT_IE  = 4;
    localparam int unsigned STAT_BITS = 5;

    localparam int unsigned ADR_DATA = 0;
    localparam int unsigned ADR_STAT = 1;
endpackage

// File: rtl/pop_fsm.sv
`timescale 1ns/1ps
module pop_fsm
    import pop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic dev_accept,
    output logic take,
    output logic release_w,
    output logic busy,
    output logic dev_valid
);
    pop_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ready)      state_d = ST_SEND;
            ST_SEND: if (dev_accept) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        take      = 1'b0;
        release_w = 1'b0;
        busy      = 1'b0;
        dev_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: take = ready;
            ST_SEND: begin
                busy      = 1'b1;
                dev_valid = 1'b1;
                release_w = dev_accept;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pop_regs.sv
`timescale 1ns/1ps
module pop_regs
    import pop_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              take,
    input  logic              release_w,
    input  logic              busy,
    output logic [DATA_W-1:0] data_q,
    output logic              ready_q,
    output logic              pend_q,
    output logic              ovr_q,
    output logic              ie_q
);
    logic wr_data, wr_stat;
    logic [DATA_W-1:0] stat_word;

    assign wr_data = we && (addr == ADDR_W'(ADR_DATA));
    assign wr_stat = we && (addr == ADDR_W'(ADR_STAT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            ready_q <= 1'b0;
            pend_q  <= 1'b0;
            ovr_q   <= 1'b0;
            ie_q    <= 1'b0;
        end else begin
            if (wr_data) begin
                if (busy) ovr_q  <= 1'b1;
                else      data_q <= wdata;
            end
            if (take)                         ready_q <= 1'b0;
            else if (wr_stat && wdata[BIT_RDY]) ready_q <= 1'b1;
            if (release_w && ie_q)            pend_q <= 1'b1;
            else if (wr_stat && wdata[BIT_PND]) pend_q <= 1'b0;
            if (wr_stat) ie_q <= wdata[BIT_IE];
        end
    end

    always_comb begin
        stat_word          = '0;
        stat_word[BIT_RDY] = ready_q;
        stat_word[BIT_BSY] = busy;
        stat_word[BIT_PND] = pend_q;
        stat_word[BIT_OVR] = ovr_q;
        stat_word[BIT_IE]  = ie_q;
    end

    always_comb begin
        rdata = '0;
        if (re) begin
            if (addr == ADDR_W'(ADR_DATA))      rdata = data_q;
            else if (addr == ADDR_W'(ADR_STAT)) rdata = stat_word;
        end
    end
endmodule

// File: rtl/polled_out_port.sv
`timescale 1ns/1ps
module polled_out_port
    import pop_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              dev_valid,
    input  logic              dev_accept,
    output logic [DATA_W-1:0] dev_data,
    output logic              irq
);
    localparam int unsigned MIN_W = STAT_BITS;

    logic take, release_w, busy;
    logic ready_q, pend_q, ovr_q, ie_q;
    logic [DATA_W-1:0] data_q;

    pop_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready      (ready_q),
        .dev_accept (dev_accept),
        .take       (take),
        .release_w  (release_w),
        .busy       (busy),
        .dev_valid  (dev_valid)
    );

    pop_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .we        (bus_we),
        .re        (bus_re),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .take      (take),
        .release_w (release_w),
        .busy      (busy),
        .data_q    (data_q),
        .ready_q   (ready_q),
        .pend_q    (pend_q),
        .ovr_q     (ovr_q),
        .ie_q      (ie_q)
    );

    assign dev_data = data_q;
    assign irq      = pend_q;

    initial begin
        if (DATA_W < MIN_W) $display("polled_out_port: DATA_W below status width");
    end
endmodule

// File: rtl/pop_chk.sv
`timescale 1ns/1ps
module pop_chk
    import pop_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              dev_valid,
    input logic              dev_accept,
    input logic [DATA_W-1:0] dev_data,
    input logic              irq,
    input logic              ready,
    input logic              busy,
    input logic              ovr,
    input logic              ie
);
    logic clr_wr;
    assign clr_wr = bus_we && (bus_addr == ADDR_W'(ADR_STAT)) && bus_wdata[BIT_PND];

    // R3
    ready_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !busy) |=> (busy && !ready && dev_valid));

    // R4
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid && !dev_accept) |=> (dev_valid && $stable(dev_data)));

    // R5
    offer_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid && dev_accept) |=> (!dev_valid && !busy));

    // R6
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> ovr);

    // R7
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid && dev_accept && ie) |=> irq);

    // R8
    irq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq);
endmodule

bind polled_out_port pop_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .dev_valid  (dev_valid),
    .dev_accept (dev_accept),
    .dev_data   (dev_data),
    .irq        (irq),
    .ready      (ready_q),
    .busy       (busy),
    .ovr        (ovr_q),
    .ie         (ie_q)
);

// File: tb/polled_out_port_test.sv
`timescale 1ns/1ps
module polled_out_port_test;
    localparam int DW = 16;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0, bus_re = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          dev_valid, dev_accept = 1'b0, irq;
    logic [DW-1:0] dev_data;

    int n_run = 0, n_fail = 0, n_cyc = 0;
    logic [DW-1:0] m_data;
    logic m_ready, m_busy, m_pend, m_ovr, m_ie;

    always #2.5 clk = ~clk;

    polled_out_port #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_valid(dev_valid), .dev_accept(dev_accept), .dev_data(dev_data),
        .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
        logic [DW-1:0] s = '0;
        if (a == 0) return m_data;
        if (a == 1) begin
            s[0] = m_ready; s[1] = m_busy; s[2] = m_pend; s[3] = m_ovr; s[4] = m_ie;
            return s;
        end
        return '0;
    endfunction

    task automatic step_model();
        logic take, rel, wd, ws;
        take = !m_busy && m_ready;
        rel  = m_busy && dev_accept;
        wd   = bus_we && bus_addr == 0;
        ws   = bus_we && bus_addr == 1;
        if (wd) begin
            if (m_busy) m_ovr = 1'b1; else m_data = bus_wdata;
        end
        if (rel && m_ie) m_pend = 1'b1;
        else if (ws && bus_wdata[2]) m_pend = 1'b0;
        if (take) m_ready = 1'b0;
        else if (ws && bus_wdata[0]) m_ready = 1'b1;
        if (ws) m_ie = bus_wdata[4];
        if (take) m_busy = 1'b1;
        else if (rel) m_busy = 1'b0;
    endtask

    task automatic cyc();
        #1;
        if (bus_re) check("R9 read", bus_rdata, exp_read(bus_addr));
        else        check("R9 idle bus", bus_rdata, 0);
        @(posedge clk);
        step_model();
        n_cyc++;
        @(negedge clk);
        check("R4 valid", dev_valid, m_busy);
        if (m_busy) check("R4 data", dev_data, m_data);
        check("R7 irq", irq, m_pend);
        bus_we = 1'b0; bus_re = 1'b0; dev_accept = 1'b0;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, logic acc);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; dev_accept = acc;
        cyc();
    endtask

    task automatic rd(logic [AW-1:0] a, logic acc);
        bus_addr = a; bus_re = 1'b1; dev_accept = acc;
        cyc();
    endtask

    task automatic idle(logic acc);
        dev_accept = acc;
        cyc();
    endtask

    task automatic peek(string tag, logic [AW-1:0] a, logic [DW-1:0] exp);
        bus_addr = a; bus_re = 1'b1;
        #1;
        check(tag, bus_rdata, exp);
        bus_re = 1'b0;
    endtask

    initial begin
        #(5 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd4242);
        m_data = '0; m_ready = 0; m_busy = 0; m_pend = 0; m_ovr = 0; m_ie = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek("R1 status", 1, 16'h0000);
        check("R1 valid", dev_valid, 0);
        check("R1 irq", irq, 0);

        // R2 data write and readback
        wr(0, 16'h00A5, 1'b0);
        peek("R2 readback", 0, 16'h00A5);

        // R3 take: ready+ie written, then controller takes
        wr(1, 16'h0011, 1'b0);
        peek("R3 ready set", 1, 16'h0011);
        idle(1'b0);
        check("R3 valid", dev_valid, 1);
        check("R3 data", dev_data, 16'h00A5);
        peek("R3 status", 1, 16'h0012);

        // R4 hold
        repeat (3) idle(1'b0);
        check("R4 still valid", dev_valid, 1);

        // R6 data write while busy
        wr(0, 16'h5A5A, 1'b0);
        peek("R6 data kept", 0, 16'h00A5);
        check("R6 dev_data", dev_data, 16'h00A5);
        peek("R6 overrun", 1, 16'h001A);

        // R5 / R7 accept ends transfer with enable set
        idle(1'b1);
        check("R5 valid low", dev_valid, 0);
        check("R7 irq set", irq, 1);
        repeat (3) idle(1'b1);
        check("R5 one transfer", dev_valid, 0);

        // R8 clear semantics
        wr(1, 16'h0010, 1'b0);
        check("R8 write0 keeps", irq, 1);
        wr(1, 16'h0014, 1'b0);
        check("R8 write1 clears", irq, 0);

        // R7 with enable clear
        wr(1, 16'h0001, 1'b0);
        idle(1'b0);
        idle(1'b1);
        check("R7 no irq", irq, 0);
        check("R5 ended", dev_valid, 0);

        // R6 overrun sticky through clears
        peek("R6 sticky", 1, 16'h0008);

        // R9 unused addresses
        wr(2, 16'hFFFF, 1'b0);
        wr(3, 16'hFFFF, 1'b0);
        peek("R9 addr2", 2, 16'h0000);
        peek("R9 addr3", 3, 16'h0000);
        peek("R9 data intact", 0, 16'h00A5);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int unsigned op;
            logic acc;
            op  = $urandom % 8;
            acc = ($urandom % 3) == 0;
            case (op)
                0, 1: wr(0, DW'($urandom), acc);
                2:    wr(1, DW'($urandom), acc);
                3, 4: rd(1, acc);
                5:    rd(0, acc);
                6:    if (op[0]) rd(AW'(2 + ($urandom % 2)), acc);
                      else       wr(AW'(2 + ($urandom % 2)), DW'($urandom), acc);
                default: idle(acc);
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule